// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked request port and an external asynchronous static RAM. A user asks for a single-word read or write with a level request. The controller latches the address, the direction and the write word. It then plays out a strobe sequence on the RAM pins and returns a one-cycle `ready` pulse when the transfer is complete. The RAM pins are a low-true select, a high-true select, a low-true output enable, a low-true write strobe, an address bus and a shared data bus. Each phase length is a whole number of clock cycles. That number is derived at elaboration from the clock period and the RAM's nanosecond limits, all of which are parameters (in picoseconds).

A write runs through three phases. In the setup phase the chip is selected, the address and data are presented and the write strobe is high. In the strobe phase the write strobe is low. In the hold phase the strobe is high again, while the data and address are still driven. The RAM commits the word on the rising edge of the write strobe. A read selects the chip and pulls the output enable low for the access phase, then registers the bus. A release phase follows, with the chip deselected, so that the RAM's drivers turn off before anything else can use the bus.

The state machine has seven states. IDLE goes to WR_SETUP on a write request and to RD_ACCESS on a read request. WR_SETUP goes to WR_STROBE, WR_STROBE goes to WR_HOLD, and WR_HOLD goes to DONE. RD_ACCESS goes to RD_RELEASE, which goes to DONE. DONE goes back to IDLE. Every move out of a timed state happens when that state's phase counter expires. DONE always lasts exactly one cycle.

Top module: `sram_ctl`

## Requirements
- R1: While `rst` is sampled high at a clock edge, from the following cycle on: `sram_ce_n`=1, `sram_ce2`=0, `sram_oe_n`=1, `sram_we_n`=1, `ready`=0, and the controller does not drive `sram_dq`. A write that was in progress is abandoned before its strobe falls, and the RAM word keeps its old value.
- R2: `sram_ce_n` is low exactly when `sram_ce2` is high. Both are asserted for the whole of WR_SETUP, WR_STROBE, WR_HOLD and RD_ACCESS, and are deasserted in IDLE, RD_RELEASE and DONE. Output enable or write strobe is low only while the chip is selected.
- R3: A request (`req`=1) is taken only in IDLE. `we`, `addr` and `wdata` are latched at the accepting edge, and later changes to them have no effect on the transfer in progress. `ready` is high for exactly one cycle per transfer.
- R4: With C(t)=max(1, ceil(t/CLK_PS)), the phase lengths are: strobe = max(C(T_PWE), C(T_SD)); setup = max(C(T_SA), C(T_AW)−strobe, C(T_SCE)−strobe); hold = max(C(T_HD), C(T_WC)−setup−strobe). The write strobe stays low for the strobe length.
- R5: During a write the controller drives `wdata` on `sram_dq` from the start of WR_SETUP to the end of WR_HOLD, and then releases the bus. `sram_addr` does not change while the chip is selected.
- R6: `sram_oe_n` stays high for the whole of every write. Output enable and write strobe are never low together. The controller never drives the bus while output enable is low.
- R7: A read holds `sram_oe_n` low for max(C(T_AA), C(T_ACE), C(T_DOE)) cycles with `sram_we_n` high. It registers `sram_dq` into `rdata` at the edge that ends that phase.
- R8: After every read, select and output enable stay inactive for C(T_HZOE) cycles (RD_RELEASE) before `ready` and before any later access.
- R9: Counting the accepting edge as the first, `ready` is high after edge 1+setup+strobe+hold for a write and after edge 1+access+release for a read.
- R10: `rdata` changes only when a read completes. It keeps its value through writes, and is valid in the cycle `ready` is high for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, high-true |
| req | input | 1 | Transfer request, held until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Word to write |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last word read |
| sram_ce_n | output | 1 | Low-true chip select |
| sram_ce2 | output | 1 | High-true chip select |
| sram_oe_n | output | 1 | Low-true output enable |
| sram_we_n | output | 1 | Low-true write strobe |
| sram_addr | output | ADDR_W | RAM address |
| sram_dq | inout | DATA_W | Shared data bus |

## Verification
The bound checker watches the pin rules on every cycle. It checks the pairing of the two selects, that no strobe is active without selection, and that output enable and write strobe are never low together. It also checks that the controller never drives the bus under an active output enable, that the address holds while selected, that `ready` is a single-cycle pulse, that the reset state is correct, and that the write strobe lasts its minimum cycle count. Only the bench scenarios can show the nanosecond-level relationships. Its behavioural RAM times the data setup and hold around the strobe's rising edge, the access time before capture, and the bus release gap after a read. The scenarios also show that data survives a round trip, that the latency matches, that inputs changed mid-transfer are ignored, and that a reset mid-write leaves memory untouched.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_RELEASE,
        ST_DONE
    } ctl_state_e;

    // whole cycles covering t_ps, never fewer than one
    function automatic int phase_cycles(input int t_ps, input int clk_ps);
        int n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W      = 2,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 1,
    parameter int HOLD_CYC   = 1,
    parameter int ACC_CYC    = 1,
    parameter int REL_CYC    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             we,
    input  logic             phase_done,
    output logic             accept,
    output logic             capture,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             ce_act,
    output logic             oe_act,
    output logic             we_act,
    output logic             drive,
    output logic             ready
);

    ctl_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    state_nxt = we ? ST_WR_SETUP : ST_RD_ACCESS;
                end
            end
            ST_WR_SETUP:   if (phase_done) state_nxt = ST_WR_STROBE;
            ST_WR_STROBE:  if (phase_done) state_nxt = ST_WR_HOLD;
            ST_WR_HOLD:    if (phase_done) state_nxt = ST_DONE;
            ST_RD_ACCESS:  if (phase_done) state_nxt = ST_RD_RELEASE;
            ST_RD_RELEASE: if (phase_done) state_nxt = ST_DONE;
            ST_DONE:       state_nxt = ST_IDLE;
            default:       state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_nxt)
            ST_WR_SETUP:   load_val = CNT_W'(SETUP_CYC - 1);
            ST_WR_STROBE:  load_val = CNT_W'(STROBE_CYC - 1);
            ST_WR_HOLD:    load_val = CNT_W'(HOLD_CYC - 1);
            ST_RD_ACCESS:  load_val = CNT_W'(ACC_CYC - 1);
            ST_RD_RELEASE: load_val = CNT_W'(REL_CYC - 1);
            default:       load_val = '0;
        endcase
    end

    assign load    = (state_nxt != state);
    assign accept  = (state == ST_IDLE) && req;
    assign capture = (state == ST_RD_ACCESS) && phase_done;

    // outputs registered from the next state so the RAM pins never glitch
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_act <= 1'b0;
            oe_act <= 1'b0;
            we_act <= 1'b0;
            drive  <= 1'b0;
            ready  <= 1'b0;
        end else begin
            ce_act <= (state_nxt == ST_WR_SETUP) || (state_nxt == ST_WR_STROBE) ||
                      (state_nxt == ST_WR_HOLD)  || (state_nxt == ST_RD_ACCESS);
            oe_act <= (state_nxt == ST_RD_ACCESS);
            we_act <= (state_nxt == ST_WR_STROBE);
            drive  <= (state_nxt == ST_WR_SETUP) || (state_nxt == ST_WR_STROBE) ||
                      (state_nxt == ST_WR_HOLD);
            ready  <= (state_nxt == ST_DONE);
        end
    end

endmodule

// File: rtl/sram_ctl_io.sv
module sram_ctl_io #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              capture,
    input  logic              drive,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sram_addr <= '0;
            wdata_q   <= '0;
        end else if (accept) begin
            sram_addr <= addr_in;
            wdata_q   <= wdata_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= sram_dq;
        end
    end

    assign sram_dq = drive ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = 10000,
    parameter int T_AA_PS   = 10000,
    parameter int T_ACE_PS  = 10000,
    parameter int T_DOE_PS  = 5000,
    parameter int T_HZOE_PS = 5000,
    parameter int T_WC_PS   = 10000,
    parameter int T_PWE_PS  = 7000,
    parameter int T_SD_PS   = 5000,
    parameter int T_HD_PS   = 5000,
    parameter int T_SA_PS   = 0,
    parameter int T_AW_PS   = 7000,
    parameter int T_SCE_PS  = 7000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              sram_ce_n,
    output logic              sram_ce2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq
);

    localparam int STROBE_CYC = imax(phase_cycles(T_PWE_PS, CLK_PS),
                                     phase_cycles(T_SD_PS, CLK_PS));
    localparam int SETUP_CYC  = imax(phase_cycles(T_SA_PS, CLK_PS),
                                     imax(phase_cycles(T_AW_PS, CLK_PS) - STROBE_CYC,
                                          phase_cycles(T_SCE_PS, CLK_PS) - STROBE_CYC));
    localparam int HOLD_CYC   = imax(phase_cycles(T_HD_PS, CLK_PS),
                                     phase_cycles(T_WC_PS, CLK_PS) - SETUP_CYC - STROBE_CYC);
    localparam int ACC_CYC    = imax(phase_cycles(T_AA_PS, CLK_PS),
                                     imax(phase_cycles(T_ACE_PS, CLK_PS),
                                          phase_cycles(T_DOE_PS, CLK_PS)));
    localparam int REL_CYC    = phase_cycles(T_HZOE_PS, CLK_PS);
    localparam int MAX_CYC    = imax(imax(SETUP_CYC, STROBE_CYC),
                                     imax(HOLD_CYC, imax(ACC_CYC, REL_CYC)));
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    logic             accept, capture, load, phase_done;
    logic [CNT_W-1:0] load_val;
    logic             ce_act, oe_act, we_act, dq_drive;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (phase_done)
    );

    sram_ctl_fsm #(
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .ACC_CYC    (ACC_CYC),
        .REL_CYC    (REL_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .we         (we),
        .phase_done (phase_done),
        .accept     (accept),
        .capture    (capture),
        .load       (load),
        .load_val   (load_val),
        .ce_act     (ce_act),
        .oe_act     (oe_act),
        .we_act     (we_act),
        .drive      (dq_drive),
        .ready      (ready)
    );

    sram_ctl_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .addr_in   (addr),
        .wdata_in  (wdata),
        .capture   (capture),
        .drive     (dq_drive),
        .sram_addr (sram_addr),
        .sram_dq   (sram_dq),
        .rdata     (rdata)
    );

    assign sram_ce_n = ~ce_act;
    assign sram_ce2  = ce_act;
    assign sram_oe_n = ~oe_act;
    assign sram_we_n = ~we_act;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W     = 19,
    parameter int STROBE_CYC = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              ce2,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ready,
    input logic              drive
);

    logic [7:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
        end else if (!we_n) begin
            if (lo_cnt != 8'hff) lo_cnt <= lo_cnt + 8'd1;
        end else begin
            lo_cnt <= '0;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (ce_n && !ce2 && oe_n && we_n && !ready && !drive));

    // R2
    select_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ce_n == !ce2);

    // R2
    strobe_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        (!oe_n || !we_n) |-> (!ce_n && ce2));

    // R2
    deselect_on_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> ce_n);

    // R3
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R4
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (lo_cnt >= 8'(STROBE_CYC)));

    // R5
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));

    // R6
    oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));

    // R6
    no_drive_under_oe_chk: assert property (@(posedge clk) disable iff (rst)
        drive |-> oe_n);

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ce_n  (sram_ce_n),
    .ce2   (sram_ce2),
    .oe_n  (sram_oe_n),
    .we_n  (sram_we_n),
    .addr  (sram_addr),
    .ready (ready),
    .drive (dq_drive)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ps/1ps
module tb_sram_ctl;

    localparam int AW      = 8;
    localparam int DW      = 16;
    localparam int CLK_PS  = 4000;
    localparam int T_AA    = 10000;
    localparam int T_ACE   = 10000;
    localparam int T_DOE   = 5000;
    localparam int T_HZOE  = 5000;
    localparam int T_WC    = 10000;
    localparam int T_PWE   = 7000;
    localparam int T_SD    = 5000;
    localparam int T_HD    = 5000;
    localparam int T_SA    = 0;
    localparam int T_AW    = 7000;
    localparam int T_SCE   = 7000;

    function automatic int cyc(input int t);
        int n;
        n = (t + CLK_PS - 1) / CLK_PS;
        return (n < 1) ? 1 : n;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // expected phase lengths from R4, R7, R8
    localparam int E_STR = mx(cyc(T_PWE), cyc(T_SD));
    localparam int E_SET = mx(cyc(T_SA), mx(cyc(T_AW) - E_STR, cyc(T_SCE) - E_STR));
    localparam int E_HLD = mx(cyc(T_HD), cyc(T_WC) - E_SET - E_STR);
    localparam int E_ACC = mx(cyc(T_AA), mx(cyc(T_ACE), cyc(T_DOE)));
    localparam int E_REL = cyc(T_HZOE);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          we  = 1'b0;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] wdata = '0;
    logic          ready;
    logic [DW-1:0] rdata;
    logic          sram_ce_n, sram_ce2, sram_oe_n, sram_we_n;
    logic [AW-1:0] sram_addr;
    wire  [DW-1:0] sram_dq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PS/2) clk = ~clk;

    sram_ctl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS),
        .T_AA_PS(T_AA), .T_ACE_PS(T_ACE), .T_DOE_PS(T_DOE), .T_HZOE_PS(T_HZOE),
        .T_WC_PS(T_WC), .T_PWE_PS(T_PWE), .T_SD_PS(T_SD), .T_HD_PS(T_HD),
        .T_SA_PS(T_SA), .T_AW_PS(T_AW), .T_SCE_PS(T_SCE)
    ) dut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ready(ready), .rdata(rdata),
        .sram_ce_n(sram_ce_n), .sram_ce2(sram_ce2), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_addr(sram_addr), .sram_dq(sram_dq)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural RAM with timing monitor ----------------
    logic [DW-1:0] mem    [256];
    logic [DW-1:0] shadow [256];
    bit     mon_on = 1'b0;
    bit     hold_watch = 1'b0;
    longint t_addr = 0, t_dq = 0, t_we_fall = 0, t_we_rise = 0;
    longint t_oe_fall = 0, t_oe_rise = 0;
    logic   ram_drv;

    assign ram_drv = !sram_ce_n && sram_ce2 && !sram_oe_n && sram_we_n;
    assign sram_dq = ram_drv ? mem[sram_addr] : {DW{1'bz}};

    always @(sram_addr) t_addr = $time;

    always @(sram_dq) begin
        if (mon_on && hold_watch) begin
            chk(($time - t_we_rise) >= T_HD, "R5 data hold after strobe rise", $time - t_we_rise, T_HD);
            hold_watch = 1'b0;
        end
        t_dq = $time;
    end

    always @(negedge sram_we_n) begin
        t_we_fall = $time;
        if (mon_on) chk(sram_oe_n == 1'b1, "R6 output enable high at write start", sram_oe_n, 1);
    end

    always @(posedge sram_we_n) begin
        if (mon_on && !sram_ce_n && sram_ce2) begin
            chk(($time - t_we_fall) >= T_PWE, "R4 strobe width", $time - t_we_fall, T_PWE);
            chk(($time - t_dq) >= T_SD, "R5 data setup", $time - t_dq, T_SD);
            chk(t_addr <= t_we_fall, "R5 address set before strobe", t_addr, t_we_fall);
            chk(($time - t_addr) >= T_AW, "R4 address to write end", $time - t_addr, T_AW);
            mem[sram_addr] = sram_dq;
            t_we_rise  = $time;
            hold_watch = 1'b1;
        end
    end

    always @(negedge sram_oe_n) t_oe_fall = $time;

    always @(posedge sram_oe_n) begin
        if (mon_on) begin
            chk(($time - t_oe_fall) >= T_DOE, "R7 output enable access", $time - t_oe_fall, T_DOE);
            chk(($time - t_addr) >= T_AA, "R7 address access", $time - t_addr, T_AA);
        end
        t_oe_rise = $time;
    end

    always @(negedge sram_ce_n) begin
        if (mon_on) chk(($time - t_oe_rise) >= T_HZOE, "R8 bus release gap", $time - t_oe_rise, T_HZOE);
    end

    // ---------------- transfer task ----------------
    task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] q, output int lat);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ready && lat < 50);
        q = rdata;
        req = 1'b0;
        if (w) shadow[a] = d;
        @(negedge clk);
        chk(ready == 1'b0, "R3 ready single cycle", ready, 0);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 16'h0125) ^ 16'h3c3c;
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        chk(sram_ce_n == 1'b1 && sram_ce2 == 1'b0, "R1 select inactive after reset", {sram_ce_n, sram_ce2}, 2'b10);
        chk(sram_oe_n == 1'b1 && sram_we_n == 1'b1, "R1 strobes inactive after reset", {sram_oe_n, sram_we_n}, 2'b11);
        chk(ready == 1'b0, "R1 ready low after reset", ready, 0);
    endtask

    task automatic t_basic();
        logic [DW-1:0] q;
        int lat;
        xfer(1'b1, 8'h10, 16'ha5c3, q, lat);
        chk(lat == 1 + E_SET + E_STR + E_HLD, "R9 write latency", lat, 1 + E_SET + E_STR + E_HLD);
        xfer(1'b0, 8'h10, '0, q, lat);
        chk(lat == 1 + E_ACC + E_REL, "R9 read latency", lat, 1 + E_ACC + E_REL);
        chk(q == 16'ha5c3, "R7 read back basic word", q, 16'ha5c3);
    endtask

    task automatic t_select_during_access();
        // R2: during a read access the selects are active, in the ready cycle they are not
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 8'h22;
        @(negedge clk);
        chk(!sram_ce_n && sram_ce2 && !sram_oe_n, "R2 selected during read", {sram_ce_n, sram_ce2, sram_oe_n}, 3'b010);
        while (!ready) @(negedge clk);
        chk(sram_ce_n && !sram_ce2, "R2 deselected while ready", {sram_ce_n, sram_ce2}, 2'b10);
        chk(rdata == shadow[8'h22], "R10 rdata valid with ready", rdata, shadow[8'h22]);
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_random();
        logic [DW-1:0] q;
        int lat;
        logic [31:0] x;
        x = 32'h1234_5678;
        for (int i = 0; i < 16; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            xfer(1'b1, AW'(i * 13 + 3), x[31:16], q, lat);
        end
        for (int i = 0; i < 16; i++) begin
            xfer(1'b0, AW'(i * 13 + 3), '0, q, lat);
            chk(q == shadow[AW'(i * 13 + 3)], "R5 random pattern read back", q, shadow[AW'(i * 13 + 3)]);
        end
    endtask

    task automatic t_edges();
        logic [DW-1:0] q;
        int lat;
        xfer(1'b1, 8'h00, 16'hffff, q, lat);
        xfer(1'b1, 8'hff, 16'h0000, q, lat);
        xfer(1'b0, 8'h00, '0, q, lat);
        chk(q == 16'hffff, "R7 all ones at lowest address", q, 16'hffff);
        xfer(1'b0, 8'hff, '0, q, lat);
        chk(q == 16'h0000, "R7 all zeros at highest address", q, 16'h0000);
    endtask

    task automatic t_busy_ignore();
        logic [DW-1:0] q;
        int lat;
        logic [DW-1:0] other;
        other = shadow[8'h41];
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 8'h40; wdata = 16'h1357;
        @(negedge clk);
        we = 1'b0; addr = 8'h41; wdata = 16'hdead;
        lat = 0;
        while (!ready && lat < 50) begin @(negedge clk); lat++; end
        req = 1'b0;
        shadow[8'h40] = 16'h1357;
        @(negedge clk);
        xfer(1'b0, 8'h40, '0, q, lat);
        chk(q == 16'h1357, "R3 latched write word kept", q, 16'h1357);
        xfer(1'b0, 8'h41, '0, q, lat);
        chk(q == other, "R3 late address change ignored", q, other);
    endtask

    task automatic t_rdata_hold();
        logic [DW-1:0] q, kept;
        int lat;
        xfer(1'b0, 8'h10, '0, kept, lat);
        xfer(1'b1, 8'h55, 16'hbeef, q, lat);
        chk(rdata == kept, "R10 rdata held across write", rdata, kept);
    endtask

    task automatic t_mid_reset();
        logic [DW-1:0] q, old;
        int lat;
        old = shadow[8'h66];
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 8'h66; wdata = ~old;
        @(negedge clk);
        rst = 1'b1; req = 1'b0;
        @(negedge clk);
        chk(sram_ce_n && !sram_ce2 && sram_we_n && sram_oe_n, "R1 reset mid write",
            {sram_ce_n, sram_ce2, sram_we_n, sram_oe_n}, 4'b1011);
        chk(ready == 1'b0, "R1 ready low in reset", ready, 0);
        rst = 1'b0;
        @(negedge clk);
        xfer(1'b0, 8'h66, '0, q, lat);
        chk(q == old, "R1 abandoned write leaves word", q, old);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = pat(i);
            shadow[i] = pat(i);
        end
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
        t_basic();
        t_select_during_access();
        t_random();
        t_edges();
        t_busy_ignore();
        t_rdata_hold();
        t_mid_reset();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule